// File: doc/BRIEF.md
# Programmable Arbitration Delay Timer

This block provides the time base for a bus arbitration sequencer. It divides the system clock by an integer equal to the clock frequency in MHz. The result is a base tick of one microsecond for any clock from 2 MHz to 40 MHz, set in 1 MHz steps. From that tick it runs two things. The first is a millisecond timer that the sequencer restarts at the start of each arbitration cycle. The second is a delay counter that loads one of sixteen programmable delays.

The sixteen delays are split into a slow bank and a fast bank of eight each. Each delay is an 8-bit count of base ticks held in its own register, written through a small configuration port. The sequencer picks a bank and an index and pulses `start`. The block answers with a one-cycle `done` pulse once the chosen number of ticks has elapsed. The effective divider, the live prescaler count and the timer value are brought out on ports so that a test can read them.

Top module: `arb_delay_timer`

## Requirements
- R1: `div_eff` equals `div_mhz` when it lies in 2..40; a value below 2 reads as 2 and a value above 40 reads as 40.
- R2: The prescaler count `div_count` runs 0,1,…,`div_eff`-1 and wraps to 0, so one base tick occurs every `div_eff` clock cycles; `div_count` never exceeds `div_eff`-1 for longer than one cycle after a divider change.
- R3: There are sixteen delay registers, all 0 after reset. A write with `cfg_we`=1 stores `cfg_data` into the register addressed by `cfg_fast` (0 = slow bank, 1 = fast bank) and `cfg_idx`. A start uses the register addressed by `sel_fast` and `dly_idx` with the same encoding.
- R4: After `start` is sampled with a selected delay D>0, `done` rises after k clock edges, where (D-1)·`div_eff`+1 ≤ k ≤ D·`div_eff`. Edges are counted from the sampling edge.
- R5: With a selected delay of 0, `done` is high in the cycle directly after the edge that samples `start`.
- R6: `done` is high for exactly one cycle per completed delay, and `busy` is low whenever `done` is high.
- R7: A `start` sampled while a delay is running abandons it and restarts from the newly selected value. No `done` is produced for the abandoned delay.
- R8: `tmr_value` counts base ticks from 0, stops at 1000 and holds there. `tmr_timeout` rises when the value reaches 1000 and stays high.
- R9: `tmr_restart` clears `tmr_value` and `tmr_timeout` on the next edge.
- R10: While `rst_n` is low, `done`, `busy`, `tmr_timeout`, `tmr_value` and `div_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 2–40 MHz in the intended use |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_mhz | input | 6 | Clock frequency in MHz, used as the divider |
| cfg_we | input | 1 | Delay register write enable |
| cfg_fast | input | 1 | Write bank: 0 slow, 1 fast |
| cfg_idx | input | 3 | Register index within the write bank |
| cfg_data | input | 8 | Delay value in base ticks |
| start | input | 1 | Start pulse for the delay counter |
| sel_fast | input | 1 | Start bank: 0 slow, 1 fast |
| dly_idx | input | 3 | Register index within the start bank |
| done | output | 1 | One-cycle pulse when the delay expires |
| busy | output | 1 | A delay is counting |
| tmr_restart | input | 1 | Clears and restarts the millisecond timer |
| tmr_value | output | 10 | Timer value in base ticks |
| tmr_timeout | output | 1 | Timer has reached 1000 ticks |
| div_eff | output | 6 | Divider after clamping, for test |
| div_count | output | 6 | Live prescaler count, for test |

## Verification
The hardest case to reach is a restart that arrives in the middle of a running delay. It must produce no `done` for the abandoned count, and it can only be seen as the absence of a pulse. The bench starts a 20-tick delay, issues a second start with a 1-tick delay ten cycles later, and queues an expectation for the second start only. Its monitor treats any `done` that finds the queue empty as a failure. The bench then waits well past the point where the first delay would have expired. The prescaler phase is free-running and unknown at each start, so delay checks use the R4 window and not a single cycle.

// File: rtl/arb_dly_pkg.sv
package arb_dly_pkg;
  typedef enum logic {
    BANK_SLOW = 1'b0,
    BANK_FAST = 1'b1
  } bank_e;
endpackage

// File: rtl/arb_tick_gen.sv
module arb_tick_gen #(
  parameter int MIN_DIV = 2,
  parameter int MAX_DIV = 40,
  parameter int DIV_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_set,
  output logic [DIV_W-1:0] div_eff,
  output logic [DIV_W-1:0] cnt_o,
  output logic             tick
);
  localparam logic [DIV_W-1:0] LO = DIV_W'(MIN_DIV);
  localparam logic [DIV_W-1:0] HI = DIV_W'(MAX_DIV);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (div_set < LO)      div_eff = LO;
    else if (div_set > HI) div_eff = HI;
    else                   div_eff = div_set;
  end

  assign tick = (cnt_q >= div_eff - DIV_W'(1));

  always_comb begin
    cnt_d = cnt_q + DIV_W'(1);
    if (tick) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  AST_DIV_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (div_eff >= LO) && (div_eff <= HI)); // R1
  AST_TICK_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == '0)); // R2
endmodule

// File: rtl/arb_ms_timer.sv
module arb_ms_timer #(
  parameter int LIMIT = 1000,
  parameter int TMR_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  output logic [TMR_W-1:0] value,
  output logic             timeout
);
  localparam logic [TMR_W-1:0] LIM = TMR_W'(LIMIT);

  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             to_q, to_d;
  logic             adv_en;

  assign adv_en = tick && (tmr_q != LIM);

  always_comb begin
    tmr_d = tmr_q;
    to_d  = to_q;
    if (restart) begin
      tmr_d = '0;
      to_d  = 1'b0;
    end else if (adv_en) begin
      tmr_d = tmr_q + TMR_W'(1);
      if (tmr_q == LIM - TMR_W'(1)) to_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
      to_q  <= 1'b0;
    end else begin
      tmr_q <= tmr_d;
      to_q  <= to_d;
    end
  end

  assign value   = tmr_q;
  assign timeout = to_q;

  AST_TMR_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_q <= LIM); // R8
  AST_TMR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    to_q |-> (tmr_q == LIM)); // R8
  AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !tick) |=> $stable(tmr_q)); // R8
  AST_TMR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> ((tmr_q == '0) && !to_q)); // R9
endmodule

// File: rtl/arb_delay_bank.sv
module arb_delay_bank #(
  parameter int DEPTH = 8,
  parameter int DLY_W = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             wr_fast,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DLY_W-1:0] wr_data,
  input  logic             rd_fast,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DLY_W-1:0] rd_data
);
  import arb_dly_pkg::*;

  logic [DLY_W-1:0] slow_q [DEPTH];
  logic [DLY_W-1:0] fast_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_reg
    logic slow_en, fast_en;
    assign slow_en = we && (bank_e'(wr_fast) == BANK_SLOW) && (wr_idx == IDX_W'(g));
    assign fast_en = we && (bank_e'(wr_fast) == BANK_FAST) && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slow_q[g] <= '0;
      else if (slow_en) slow_q[g] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       fast_q[g] <= '0;
      else if (fast_en) fast_q[g] <= wr_data;
    end
  end

  always_comb begin
    if (bank_e'(rd_fast) == BANK_FAST) rd_data = fast_q[rd_idx];
    else                               rd_data = slow_q[rd_idx];
  end
endmodule

// File: rtl/arb_delay_counter.sv
module arb_delay_counter #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DLY_W-1:0] load_val,
  input  logic             tick,
  output logic             done,
  output logic             busy
);
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic             expire;

  assign expire = busy_q && tick && (cnt_q == DLY_W'(1));

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (start) begin
      cnt_d  = load_val;
      busy_d = (load_val != '0);
      done_d = (load_val == '0);
    end else if (busy_q && tick) begin
      cnt_d = cnt_q - DLY_W'(1);
      if (expire) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;
  assign busy = busy_q;

  AST_ZERO_DLY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (load_val == '0)) |=> done_q); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q); // R6
  AST_RESTART_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (load_val != '0)) |=> (busy_q && !done_q)); // R7
endmodule

// File: rtl/arb_delay_timer.sv
module arb_delay_timer #(
  parameter int MIN_DIV    = 2,
  parameter int MAX_DIV    = 40,
  parameter int DIV_W      = 6,
  parameter int DLY_W      = 8,
  parameter int BANK_DEPTH = 8,
  parameter int TMR_LIMIT  = 1000,
  parameter int IDX_W      = $clog2(BANK_DEPTH),
  parameter int TMR_W      = $clog2(TMR_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_mhz,
  input  logic             cfg_we,
  input  logic             cfg_fast,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [DLY_W-1:0] cfg_data,
  input  logic             start,
  input  logic             sel_fast,
  input  logic [IDX_W-1:0] dly_idx,
  output logic             done,
  output logic             busy,
  input  logic             tmr_restart,
  output logic [TMR_W-1:0] tmr_value,
  output logic             tmr_timeout,
  output logic [DIV_W-1:0] div_eff,
  output logic [DIV_W-1:0] div_count
);
  logic             base_tick;
  logic [DLY_W-1:0] sel_val;

  arb_tick_gen #(.MIN_DIV(MIN_DIV), .MAX_DIV(MAX_DIV), .DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div_set(div_mhz),
    .div_eff(div_eff), .cnt_o(div_count), .tick(base_tick)
  );

  arb_ms_timer #(.LIMIT(TMR_LIMIT), .TMR_W(TMR_W)) u_ms (
    .clk(clk), .rst_n(rst_n), .tick(base_tick), .restart(tmr_restart),
    .value(tmr_value), .timeout(tmr_timeout)
  );

  arb_delay_bank #(.DEPTH(BANK_DEPTH), .DLY_W(DLY_W), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wr_fast(cfg_fast),
    .wr_idx(cfg_idx), .wr_data(cfg_data),
    .rd_fast(sel_fast), .rd_idx(dly_idx), .rd_data(sel_val)
  );

  arb_delay_counter #(.DLY_W(DLY_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .start(start), .load_val(sel_val),
    .tick(base_tick), .done(done), .busy(busy)
  );
endmodule

// File: tb/arb_delay_timer_bench.sv
module arb_delay_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] div_mhz;
  logic       cfg_we, cfg_fast, start, sel_fast, tmr_restart;
  logic [2:0] cfg_idx, dly_idx;
  logic [7:0] cfg_data;
  logic       done, busy, tmr_timeout;
  logic [9:0] tmr_value;
  logic [5:0] div_eff, div_count;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;
  bit prev_done = 1'b0;

  typedef struct {
    int    lo;
    int    hi;
    int    t0;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  arb_delay_timer u_arb_delay_timer (
    .clk(clk), .rst_n(rst_n), .div_mhz(div_mhz),
    .cfg_we(cfg_we), .cfg_fast(cfg_fast), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .start(start), .sel_fast(sel_fast), .dly_idx(dly_idx),
    .done(done), .busy(busy),
    .tmr_restart(tmr_restart), .tmr_value(tmr_value), .tmr_timeout(tmr_timeout),
    .div_eff(div_eff), .div_count(div_count)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: pops one expectation per done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      chk(!prev_done, "R6 pulse width", 2, 1);
      chk(!busy, "R6 busy low at done", int'(busy), 0);
      if (sb.size() == 0) begin
        chk(1'b0, "R7 unexpected done", 1, 0);
      end else begin
        exp_t e;
        int   el;
        e  = sb.pop_front();
        el = cyc - e.t0;
        chk((el >= e.lo) && (el <= e.hi), e.tag, el, e.lo);
      end
    end
    prev_done = done;
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_write(input bit fast, input int idx, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_fast = fast; cfg_idx = 3'(idx); cfg_data = 8'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Driver: issues a start and queues the window the done must fall in
  task automatic go(input bit fast, input int idx, input int d, input int dv,
                    input bit push, input string tag);
    @(negedge clk);
    sel_fast = fast; dly_idx = 3'(idx); start = 1'b1;
    if (push) begin
      exp_t e;
      e.t0  = cyc + 1;
      e.lo  = (d == 0) ? 0 : (d - 1) * dv + 1;
      e.hi  = d * dv;
      e.tag = tag;
      sb.push_back(e);
    end
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic div_chk(input int setv, input int expv);
    @(negedge clk);
    div_mhz = 6'(setv);
    wait_cyc(2);
    chk(int'(div_eff) == expv, "R1 divider clamp", int'(div_eff), expv);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
  end

  initial begin
    rst_n = 1'b0; div_mhz = 6'd2;
    cfg_we = 1'b0; cfg_fast = 1'b0; cfg_idx = '0; cfg_data = '0;
    start = 1'b0; sel_fast = 1'b0; dly_idx = '0; tmr_restart = 1'b0;
    wait_cyc(3);
    chk(!done && !busy && !tmr_timeout, "R10 reset flags", int'({done, busy, tmr_timeout}), 0);
    chk(tmr_value == 0, "R10 reset timer", int'(tmr_value), 0);
    chk(div_count == 0, "R10 reset prescaler", int'(div_count), 0);
    rst_n = 1'b1;

    // R1 clamp
    div_chk(0, 2);
    div_chk(1, 2);
    div_chk(17, 17);
    div_chk(40, 40);
    div_chk(41, 40);
    div_chk(63, 40);

    // R2 prescaler at 5: in range, four wraps in twenty cycles
    div_chk(5, 5);
    begin
      int zeros = 0;
      int maxc  = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (div_count == 0) zeros++;
        if (int'(div_count) > maxc) maxc = int'(div_count);
      end
      chk(zeros == 4, "R2 tick period", zeros, 4);
      chk(maxc == 4, "R2 count range", maxc, 4);
    end

    // R3 unwritten register reads 0 -> R5 immediate done
    div_chk(2, 2);
    go(1'b0, 2, 0, 2, 1'b1, "R3 reset value zero");
    wait_cyc(4);

    cfg_write(1'b0, 1, 3);
    cfg_write(1'b0, 7, 20);
    cfg_write(1'b1, 0, 1);
    cfg_write(1'b1, 5, 7);
    cfg_write(1'b1, 7, 255);

    go(1'b0, 0, 0, 2, 1'b1, "R5 zero delay");
    wait_cyc(4);
    go(1'b0, 1, 3, 2, 1'b1, "R4 slow 3");
    wait_cyc(12);
    go(1'b0, 7, 20, 2, 1'b1, "R4 slow 20");
    wait_cyc(50);
    go(1'b1, 0, 1, 2, 1'b1, "R4 fast 1");
    wait_cyc(6);
    go(1'b1, 5, 7, 2, 1'b1, "R3 fast bank 7");
    wait_cyc(20);
    go(1'b0, 5, 0, 2, 1'b1, "R3 slow bank separate");
    wait_cyc(4);
    go(1'b1, 7, 255, 2, 1'b1, "R4 fast 255");
    wait_cyc(520);

    div_chk(5, 5);
    go(1'b1, 5, 7, 5, 1'b1, "R4 fast 7 at div 5");
    wait_cyc(45);

    // R7 restart mid-count: only the second start may finish
    div_chk(2, 2);
    go(1'b0, 7, 20, 2, 1'b0, "");
    wait_cyc(10);
    go(1'b1, 0, 1, 2, 1'b1, "R7 restart");
    wait_cyc(80);
    chk(!busy, "R7 idle after restart", int'(busy), 0);
    chk(sb.size() == 0, "R4 all delays finished", sb.size(), 0);

    // R8/R9 millisecond timer at divider 2
    @(negedge clk); tmr_restart = 1'b1;
    @(negedge clk); tmr_restart = 1'b0;
    chk(tmr_value == 0 && !tmr_timeout, "R9 restart clears", int'(tmr_value), 0);
    wait_cyc(1990);
    chk(!tmr_timeout, "R8 no early timeout", int'(tmr_timeout), 0);
    wait_cyc(30);
    chk(tmr_timeout, "R8 timeout set", int'(tmr_timeout), 1);
    chk(tmr_value == 1000, "R8 value at limit", int'(tmr_value), 1000);
    wait_cyc(50);
    chk(tmr_value == 1000 && tmr_timeout, "R8 saturates", int'(tmr_value), 1000);
    @(negedge clk); tmr_restart = 1'b1;
    @(negedge clk); tmr_restart = 1'b0;
    chk(tmr_value == 0 && !tmr_timeout, "R9 restart after timeout", int'(tmr_value), 0);

    wait_cyc(5);
    summary();
  end
endmodule